// File: doc/BRIEF.md
# Two-Phase I2C Temperature Word Fetcher

This block is an I2C bus master with one fixed job: fetch a 16-bit temperature word from a sensor whose address is fixed. A single pulse on the request input starts the work. The block first waits until both bus lines are sampled high. It then runs a write transaction that aims the sensor's internal pointer at its temperature register and closes that transaction with a stop. Next it opens a fresh transaction that reads two bytes. The most significant byte comes first. The master acknowledges each byte and then issues a stop. The word is then published and a one-cycle completion pulse is given.

Both bus lines are open drain. The block only ever pulls a line low through an enable output, and it reads the real line level through synchronised inputs. Bit timing comes from a quarter-period divider parameter. A missing acknowledge on any byte the master sends ends the sequence early with a stop and raises an error flag. In that case the previously published word is kept. Multi-master arbitration, clock stretching, sensor configuration and temperature scaling are not part of the block.

Top module: `tsense_rd_seq`

## Requirements
- R1: After a request is accepted, no start condition is issued until both SCL and SDA have been sampled high, and the block waits as long as either line stays low.
- R2: A start is SDA pulled low while SCL is released. A stop is SDA released while SCL is released. Each transaction has exactly one start and one stop.
- R3: The first byte of the write transaction is the 7-bit address 1001000 followed by a 0 write bit, giving 0x90 on the wire.
- R4: After each byte the master sends, it releases SDA for one bit and samples it. A low level is an acknowledge and a high level is a missing acknowledge.
- R5: The second byte of the write transaction is the pointer value 0x00. After its acknowledge the master issues a stop.
- R6: The read transaction opens with a new start and the byte 0x91 (the same address with the read bit set to 1).
- R7: The first received byte lands in temp_word[15:8] and the second in temp_word[7:0]. The master drives SDA low as an acknowledge after each of the two received bytes.
- R8: Bits are sent MSB first. During a data or acknowledge bit, SDA changes only while SCL is low.
- R9: The outputs are pull-low enables only. During the data bits that the sensor sends, the master keeps SDA released and takes the data from the sampled line level.
- R10: If any sent byte is not acknowledged, the block issues a stop, sets nack_err and pulses done, and temp_word keeps its previous value. nack_err clears when the next request is accepted.
- R11: Every SCL low phase lasts 2*QDIV clock cycles. Every SDA change made while SCL is low happens exactly QDIV cycles after SCL fell.
- R12: A request that arrives while busy is ignored. done pulses for one cycle, with busy low, only after the final stop, and only then are temp_word and nack_err updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to fetch one temperature word |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| nack_err | output | 1 | Last sequence ended on a missing acknowledge |
| temp_word | output | 16 | Last temperature word fetched successfully |

## Verification
The in-line properties check the following on every cycle:
- SDA never moves while SCL is released during a data bit.
- SCL stays released throughout a start condition, and a stop leaves both lines released.
- A start is requested only on an idle bus.
- temp_word changes only with a successful done.
- done arrives with both lines released.

Other behaviour can only be shown by the bench scenarios, using a sensor model on the open-drain bus. These cover the byte values and their bit order, the acknowledge the master gives after each read byte, the exact quarter-period placement of the SCL low phases and SDA changes, the wait on a held-low line, the early stops at each of the three possible missing-acknowledge points, and a request made while busy having no effect.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

   // bit-level bus operations understood by the engine
   typedef enum logic [1:0] {
      BC_START = 2'd0,
      BC_STOP  = 2'd1,
      BC_BIT   = 2'd2
   } bus_cmd_e;

   // sequencer states
   typedef enum logic [2:0] {
      SQ_IDLE    = 3'd0,
      SQ_WAITBUS = 3'd1,
      SQ_START   = 3'd2,
      SQ_BYTE    = 3'd3,
      SQ_STOP    = 3'd4,
      SQ_FIN     = 3'd5
   } seq_st_e;

   // byte slots of the full sequence
   localparam logic [2:0] SLOT_ADDR_WR = 3'd0;
   localparam logic [2:0] SLOT_POINTER = 3'd1;
   localparam logic [2:0] SLOT_ADDR_RD = 3'd2;
   localparam logic [2:0] SLOT_DATA_HI = 3'd3;
   localparam logic [2:0] SLOT_DATA_LO = 3'd4;

endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $fatal(1, "tsr_sync: WIDTH must be at least 1");
   end
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $fatal(1, "tsr_sync: STAGES must be 0 to 4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] ff [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff[i] <= '1;   // released bus lines idle high
            end else if (i == 0) begin
               ff[i] <= d;
            end else begin
               ff[i] <= ff[(i > 0) ? i - 1 : 0];
            end
         end
      end
      assign q = ff[STAGES-1];
   end

endmodule

// File: rtl/tsr_qtick.sv
module tsr_qtick #(
   parameter int QDIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);

   if (QDIV < 2) begin : g_bad_div
      $fatal(1, "tsr_qtick: QDIV must be at least 2");
   end

   localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || !run || cnt == LAST) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = run && !restart && (cnt == LAST);

endmodule

// File: rtl/tsr_bit_eng.sv
module tsr_bit_eng
   import tsr_pkg::*;
#(
   parameter int QDIV = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     go,
   input  bus_cmd_e cmd,
   input  logic     tx_bit,
   input  logic     sda_s,
   output logic     scl_oe,
   output logic     sda_oe,
   output logic     rx_bit,
   output logic     fin
);

   logic       active;
   logic       accept;
   logic       tick;
   bus_cmd_e   kind;
   logic [1:0] q;
   logic       bit_r;

   assign accept = go && !active;

   tsr_qtick #(.QDIV(QDIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (active),
      .restart(accept),
      .tick   (tick)
   );

   // pin enables {scl_oe, sda_oe} for one quarter of an operation
   function automatic logic [1:0] pin_state(bus_cmd_e k, logic [1:0] ph,
                                            logic b, logic sda_prev);
      logic [1:0] r;
      case (k)
         BC_START: r = (ph < 2'd2) ? 2'b00 : 2'b01;
         BC_STOP: begin
            case (ph)
               2'd0:    r = {1'b1, sda_prev};
               2'd1:    r = 2'b11;
               2'd2:    r = 2'b01;
               default: r = 2'b00;
            endcase
         end
         default: begin
            if (ph == 2'd0)      r = {1'b1, sda_prev};
            else if (ph == 2'd1) r = {1'b1, ~b};
            else                 r = {1'b0, ~b};
         end
      endcase
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         kind   <= BC_BIT;
         q      <= 2'd0;
         bit_r  <= 1'b1;
         scl_oe <= 1'b0;
         sda_oe <= 1'b0;
         rx_bit <= 1'b1;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (accept) begin
            active           <= 1'b1;
            kind             <= cmd;
            bit_r            <= tx_bit;
            q                <= 2'd0;
            {scl_oe, sda_oe} <= pin_state(cmd, 2'd0, tx_bit, sda_oe);
         end else if (tick) begin
            if (kind == BC_BIT && q == 2'd2) begin
               rx_bit <= sda_s;   // middle of the SCL high phase
            end
            if (q == 2'd3) begin
               active <= 1'b0;
               fin    <= 1'b1;
            end else begin
               q                <= q + 2'd1;
               {scl_oe, sda_oe} <= pin_state(kind, q + 2'd1, bit_r, sda_oe);
            end
         end
      end
   end

   // R8: during a bit, SDA may not move while SCL stays released
   p_sda_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (kind != BC_BIT));

   // R2: SCL stays released for the whole start condition
   p_start_scl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && kind == BC_START) |-> !scl_oe);

   // R2: a finished stop leaves both lines released
   p_stop_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && kind == BC_STOP) |-> (!scl_oe && !sda_oe));

endmodule

// File: rtl/tsr_seq_ctrl.sv
module tsr_seq_ctrl
   import tsr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1001000,
   parameter logic [7:0] PTR_VAL  = 8'h00,
   parameter int         WORD_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              bus_idle,
   input  logic              eng_fin,
   input  logic              eng_rx,
   output logic              eng_go,
   output bus_cmd_e          eng_cmd,
   output logic              eng_tx,
   output logic              busy,
   output logic              done,
   output logic              nack_err,
   output logic [WORD_W-1:0] temp_word
);

   if (WORD_W != 16) begin : g_bad_word
      $fatal(1, "tsr_seq_ctrl: WORD_W must be 16 (two bytes)");
   end

   localparam logic [3:0] ACK_BIT = 4'd8;

   seq_st_e           st;
   logic [2:0]        ph;
   logic [3:0]        bitc;
   logic [7:0]        shreg;
   logic [7:0]        msb_r;
   logic              wait_r;
   logic              fail_r;
   logic              rd_phase;
   logic [WORD_W-1:0] word_r;
   logic              done_r;
   logic              err_r;

   function automatic logic [7:0] byte_for(logic [2:0] slot);
      case (slot)
         SLOT_ADDR_WR: return {DEV_ADDR, 1'b0};
         SLOT_POINTER: return PTR_VAL;
         SLOT_ADDR_RD: return {DEV_ADDR, 1'b1};
         default:      return 8'hFF;   // released while receiving
      endcase
   endfunction

   assign rd_phase = (ph >= SLOT_DATA_HI);
   assign eng_go   = ((st == SQ_START) || (st == SQ_BYTE) || (st == SQ_STOP)) && !wait_r;
   assign eng_cmd  = (st == SQ_START) ? BC_START :
                     (st == SQ_STOP)  ? BC_STOP  : BC_BIT;
   assign eng_tx   = (bitc != ACK_BIT) ? shreg[7] : ~rd_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         ph     <= 3'd0;
         bitc   <= 4'd0;
         shreg  <= 8'hFF;
         msb_r  <= 8'h00;
         wait_r <= 1'b0;
         fail_r <= 1'b0;
         word_r <= '0;
         done_r <= 1'b0;
         err_r  <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (eng_go) wait_r <= 1'b1;
         case (st)
            SQ_IDLE: begin
               if (start_req) begin
                  st     <= SQ_WAITBUS;
                  ph     <= SLOT_ADDR_WR;
                  fail_r <= 1'b0;
                  err_r  <= 1'b0;
               end
            end
            SQ_WAITBUS: begin
               if (bus_idle) st <= SQ_START;
            end
            SQ_START: begin
               if (eng_fin) begin
                  wait_r <= 1'b0;
                  st     <= SQ_BYTE;
                  bitc   <= 4'd0;
                  shreg  <= byte_for(ph);
               end
            end
            SQ_BYTE: begin
               if (eng_fin) begin
                  wait_r <= 1'b0;
                  if (bitc != ACK_BIT) begin
                     shreg <= {shreg[6:0], eng_rx};
                     bitc  <= bitc + 4'd1;
                  end else if (!rd_phase && eng_rx) begin
                     fail_r <= 1'b1;
                     st     <= SQ_STOP;
                  end else begin
                     if (ph == SLOT_DATA_HI) msb_r <= shreg;
                     if (ph == SLOT_POINTER || ph == SLOT_DATA_LO) begin
                        st <= SQ_STOP;
                     end else begin
                        ph    <= ph + 3'd1;
                        bitc  <= 4'd0;
                        shreg <= byte_for(ph + 3'd1);
                     end
                  end
               end
            end
            SQ_STOP: begin
               if (eng_fin) begin
                  wait_r <= 1'b0;
                  if (fail_r || ph == SLOT_DATA_LO) begin
                     st <= SQ_FIN;
                  end else begin
                     ph <= SLOT_ADDR_RD;
                     st <= SQ_WAITBUS;
                  end
               end
            end
            SQ_FIN: begin
               done_r <= 1'b1;
               err_r  <= fail_r;
               if (!fail_r) word_r <= {msb_r, shreg};
               st     <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy      = (st != SQ_IDLE);
   assign done      = done_r;
   assign nack_err  = err_r;
   assign temp_word = word_r;

   // R1: a start is only requested on a bus sampled idle
   p_idle_before_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_go && eng_cmd == BC_START) |-> bus_idle);

   // R10: the published word moves only with a successful completion
   p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_word != $past(temp_word)) |-> (done && !nack_err));

   // R12: completion is reported with the block no longer busy
   p_done_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: rtl/tsense_rd_seq.sv
module tsense_rd_seq
   import tsr_pkg::*;
#(
   parameter int         QDIV        = 125,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'b1001000,
   parameter logic [7:0] PTR_VAL     = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_req,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        scl_oe,
   output logic        sda_oe,
   output logic        busy,
   output logic        done,
   output logic        nack_err,
   output logic [15:0] temp_word
);

   if (QDIV <= SYNC_STAGES) begin : g_bad_cfg
      $fatal(1, "tsense_rd_seq: QDIV must exceed SYNC_STAGES");
   end

   logic [1:0] lines_s;
   logic       bus_idle;
   logic       eng_go;
   bus_cmd_e   eng_cmd;
   logic       eng_tx;
   logic       eng_rx;
   logic       eng_fin;

   tsr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({scl_i, sda_i}),
      .q    (lines_s)
   );

   assign bus_idle = lines_s[1] & lines_s[0];

   tsr_bit_eng #(.QDIV(QDIV)) u_eng (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (eng_go),
      .cmd   (eng_cmd),
      .tx_bit(eng_tx),
      .sda_s (lines_s[0]),
      .scl_oe(scl_oe),
      .sda_oe(sda_oe),
      .rx_bit(eng_rx),
      .fin   (eng_fin)
   );

   tsr_seq_ctrl #(.DEV_ADDR(DEV_ADDR), .PTR_VAL(PTR_VAL), .WORD_W(16)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_req(start_req),
      .bus_idle (bus_idle),
      .eng_fin  (eng_fin),
      .eng_rx   (eng_rx),
      .eng_go   (eng_go),
      .eng_cmd  (eng_cmd),
      .eng_tx   (eng_tx),
      .busy     (busy),
      .done     (done),
      .nack_err (nack_err),
      .temp_word(temp_word)
   );

   // R12: done only after the final stop has left both lines released
   p_done_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/sim_tsense_rd_seq.sv
`timescale 1ns/1ps
module sim_tsense_rd_seq;

   localparam int QD = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_req = 1'b0;
   logic        scl_oe, sda_oe, busy, done, nack_err;
   logic [15:0] temp_word;
   logic        s_drv = 1'b0;
   logic        ext_hold = 1'b0;
   logic        scl_ln, sda_ln;

   int nchk = 0;
   int nfail = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   assign scl_ln = !scl_oe;
   assign sda_ln = !(sda_oe || s_drv || ext_hold);

   tsense_rd_seq #(.QDIV(QD), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .start_req(start_req),
      .scl_i(scl_ln), .sda_i(sda_ln),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
      .nack_err(nack_err), .temp_word(temp_word)
   );

   // ---------------- sensor model ----------------
   logic [7:0] t_msb = 8'h00, t_lsb = 8'h00;
   int   nack_at = -1;
   int   nstart = 0, nstop = 0, mack = 0, mnack = 0, rxidx = 0;
   int   collide = 0, ndone = 0;
   logic [7:0] rxlog [4];
   int   bitc = 0, bytec = 0;
   logic [7:0] sh = 8'h00;
   logic rw = 1'b0, addr_nak = 1'b0, in_tx = 1'b0, s_txbit = 1'b0;
   logic p_scl = 1'b1, p_sda = 1'b1;

   always @(negedge clk) begin
      logic scl_v, sda_v;
      logic [7:0] txb;
      scl_v = scl_ln;
      sda_v = sda_ln;
      if (scl_v && s_txbit && sda_oe) collide++;
      if (scl_v && p_scl && p_sda && !sda_v) begin
         nstart++; bitc = 0; bytec = 0; s_drv = 1'b0; in_tx = 1'b0;
         rw = 1'b0; addr_nak = 1'b0; s_txbit = 1'b0;
      end else if (scl_v && p_scl && !p_sda && sda_v) begin
         nstop++; bitc = 0; s_drv = 1'b0; in_tx = 1'b0; s_txbit = 1'b0;
      end else if (scl_v && !p_scl) begin
         if (bitc < 8) begin
            if (!in_tx) sh = {sh[6:0], sda_v};
         end else if (in_tx) begin
            if (!sda_v) mack++; else mnack++;
         end
         bitc++;
         if (bitc == 8 && !in_tx) begin
            if (rxidx < 4) rxlog[rxidx] = sh;
            if (bytec == 0) rw = sh[0];
            if (rxidx == nack_at && bytec == 0) addr_nak = 1'b1;
            rxidx++;
         end
         if (bitc == 9) begin
            bitc = 0;
            bytec++;
            in_tx = rw && !addr_nak && (bytec >= 1) && (bytec <= 2);
         end
      end else if (!scl_v && p_scl) begin
         s_drv = 1'b0;
         s_txbit = 1'b0;
         if (!in_tx && bitc == 8) begin
            if ((rxidx - 1) != nack_at) s_drv = 1'b1;
         end else if (in_tx && bitc < 8) begin
            txb = (bytec == 1) ? t_msb : t_lsb;
            s_drv = !txb[7 - bitc];
            s_txbit = 1'b1;
         end
      end
      p_scl = scl_v;
      p_sda = sda_ln;
      if (done) ndone++;
   end

   // ---------------- timing monitor ----------------
   int   lowcnt = 0, nlow = 0, tviol = 0, sviol = 0;
   logic m_scl = 1'b0, m_sda = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_oe) begin
            lowcnt = m_scl ? lowcnt + 1 : 1;
            if (m_scl && (sda_oe != m_sda) && lowcnt != QD + 1) sviol++;
         end else if (m_scl) begin
            nlow++;
            if (lowcnt != 2 * QD) tviol++;
         end
      end
      m_scl = scl_oe;
      m_sda = sda_oe;
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_logs();
      nstart = 0; nstop = 0; mack = 0; mnack = 0; rxidx = 0; ndone = 0;
      for (int i = 0; i < 4; i++) rxlog[i] = 8'hEE;
   endtask

   task automatic kick();
      @(negedge clk) start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
   endtask

   task automatic wait_done();
      int t;
      t = 0;
      while (!done && t < 20000) begin
         @(negedge clk);
         t++;
      end
      check(done, "R12", "done pulse seen", done, 1);
      check(!busy, "R12", "busy low at done", busy, 0);
      repeat (8) @(negedge clk);
   endtask

   function automatic logic [15:0] expect_word(logic [7:0] hi, logic [7:0] lo);
      return {hi, lo};
   endfunction

   logic [15:0] exp_word = 16'h0000;

   task automatic run_ok(input logic [7:0] hi, input logic [7:0] lo);
      t_msb = hi; t_lsb = lo; nack_at = -1;
      clear_logs();
      kick();
      wait_done();
      exp_word = expect_word(hi, lo);
      check(temp_word == exp_word, "R7", "temp_word", temp_word, exp_word);
      check(!nack_err, "R4", "no error on full ack", nack_err, 0);
      check(rxlog[0] == 8'h90, "R3", "write address byte", rxlog[0], 8'h90);
      check(rxlog[1] == 8'h00, "R5", "pointer byte", rxlog[1], 8'h00);
      check(rxlog[2] == 8'h91, "R6", "read address byte", rxlog[2], 8'h91);
      check(nstart == 2 && nstop == 2, "R2", "start/stop count", nstart * 16 + nstop, 8'h22);
      check(mack == 2 && mnack == 0, "R7", "master acks of read bytes", mack * 16 + mnack, 8'h20);
      check(ndone == 1, "R12", "single done pulse", ndone, 1);
   endtask

   task automatic run_nack(input int slot);
      t_msb = 8'h5A; t_lsb = 8'hC3; nack_at = slot;
      clear_logs();
      kick();
      wait_done();
      check(nack_err, "R10", "error flag after missing ack", nack_err, 1);
      check(temp_word == exp_word, "R10", "word kept after missing ack", temp_word, exp_word);
      check(nstart == ((slot == 2) ? 2 : 1), "R10", "starts before abort", nstart, (slot == 2) ? 2 : 1);
      check(nstop == nstart, "R10", "stop issued on abort", nstop, nstart);
      check(mack == 0, "R4", "no read data after missing ack", mack, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      nfail++;
      $display("FAIL R12 watchdog expired: done %0d expected 1", done);
      $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [7:0] hi, lo;
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      check(!busy && !done && !nack_err, "R12", "reset flags", {busy, done, nack_err}, 0);
      check(temp_word == 16'h0000, "R10", "reset word", temp_word, 0);
      check(!scl_oe && !sda_oe, "R9", "lines released in reset", {scl_oe, sda_oe}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // directed values
      run_ok(8'h00, 8'h00);
      run_ok(8'hFF, 8'hFF);
      run_ok(8'h80, 8'h01);
      // random values
      for (int i = 0; i < 6; i++) begin
         hi = 8'($urandom);
         lo = 8'($urandom);
         run_ok(hi, lo);
      end

      // missing acknowledge on each sent byte
      run_nack(0);
      check(rxlog[0] == 8'h90, "R3", "address byte before abort", rxlog[0], 8'h90);
      run_nack(1);
      check(rxlog[1] == 8'h00, "R5", "pointer byte before abort", rxlog[1], 8'h00);
      run_nack(2);
      check(rxlog[2] == 8'h91, "R6", "read address before abort", rxlog[2], 8'h91);

      // error cleared by a following good sequence
      run_ok(8'h19, 8'h70);

      // request while busy is ignored
      t_msb = 8'h3C; t_lsb = 8'hA5; nack_at = -1;
      clear_logs();
      kick();
      repeat (300) @(negedge clk);
      check(busy, "R12", "busy mid sequence", busy, 1);
      kick();
      wait_done();
      repeat (600) @(negedge clk);
      check(ndone == 1, "R12", "extra request ignored", ndone, 1);
      check(nstart == 2, "R12", "no extra transaction", nstart, 2);
      check(!busy, "R12", "idle after ignored request", busy, 0);
      exp_word = expect_word(8'h3C, 8'hA5);
      check(temp_word == exp_word, "R12", "word after ignored request", temp_word, exp_word);

      // idle wait: SDA held low by another party
      t_msb = 8'h0F; t_lsb = 8'hF0; nack_at = -1;
      @(negedge clk) ext_hold = 1'b1;
      repeat (4) @(negedge clk);
      clear_logs();
      kick();
      repeat (20 * QD) @(negedge clk);
      check(busy, "R1", "request accepted while held", busy, 1);
      check(!scl_oe && !sda_oe, "R1", "no drive on held bus", {scl_oe, sda_oe}, 0);
      check(nstart == 0, "R1", "no start on held bus", nstart, 0);
      @(negedge clk) ext_hold = 1'b0;
      repeat (2) @(negedge clk);
      clear_logs();
      wait_done();
      exp_word = expect_word(8'h0F, 8'hF0);
      check(temp_word == exp_word, "R1", "word after bus freed", temp_word, exp_word);
      check(nstart == 2, "R1", "starts after bus freed", nstart, 2);

      // whole-run bus properties
      check(nlow > 100, "R11", "SCL low phases measured", nlow, 101);
      check(tviol == 0, "R11", "SCL low width violations", tviol, 0);
      check(sviol == 0, "R11", "SDA change placement violations", sviol, 0);
      check(collide == 0, "R9", "master drove SDA in sensor data bits", collide, 0);

      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

endmodule